// File: doc/BRIEF.md
# Occupancy-Driven Serial DMA Request Controller

This block turns the fill levels of a serial port's transmit and receive FIFOs into DMA request lines. The transmit side asks for data while its FIFO is running low. The receive side asks to be drained once its FIFO has filled to a chosen mark, or when a receive timeout flags characters that have been waiting too long. A single select bit picks one of two threshold pairs, so the same port can run either single-transfer or burst-style demand DMA.

Two fairness policies govern how long a request may stay up. In the time-limited policy, a burst timer counts the cycles of continuous DMA activity. Once the count reaches a parameterised cycle limit, both requests are dropped for one cycle so that other bus masters get a turn. In the hold policy, a request stays up once it has been raised until its FIFO is full (transmit) or empty (receive). A swap bit steers the two requests onto the two external channel outputs in either order, so one DMA channel can serve whichever direction software selects.

Top module: `dma_req_ctrl`

## Requirements
- R1: While rst_n is low, and in the cycle after any clock edge at which port_en is low, both channel request outputs are 0.
- R2: A transmit request is raised one clock after an edge at which port_en is 1 and tx_level is strictly below the transmit threshold.
- R3: A receive request is raised one clock after an edge at which port_en is 1 and either rx_level is at or above the receive threshold or rx_tmo is 1.
- R4: With thr_sel = 0 the transmit threshold is 1 and the receive threshold is 4. With thr_sel = 1 both thresholds are 8.
- R5: With fair_sel = 0 each request follows demand. It falls one clock after its threshold condition (and, for receive, the timeout) stops holding.
- R6: With fair_sel = 1 a raised transmit request stays up until an edge with tx_full = 1, and a raised receive request stays up until an edge with rx_empty = 1. Either one is raised again only when its threshold condition holds afresh.
- R7: With fair_sel = 0, after BURST_CYC consecutive cycles of DMA activity both requests are low for exactly one cycle. They then resume if demand remains.
- R8: DMA activity means any request output or either acknowledge input is high. The burst count restarts after any cycle without activity. With fair_sel = 1 requests are never cut by the timer.
- R9: With swap_sel = 0, dma0_req carries the transmit request and dma1_req carries the receive request. With swap_sel = 1 the mapping is reversed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_en | input | 1 | Port enable; requests are held low when 0 |
| thr_sel | input | 1 | Threshold pair select |
| fair_sel | input | 1 | 0: time-limited bursts, 1: hold until full/empty |
| swap_sel | input | 1 | Swaps the request-to-channel mapping |
| tx_level | input | LVL_W | Transmit FIFO occupancy |
| rx_level | input | LVL_W | Receive FIFO occupancy |
| tx_full | input | 1 | Transmit FIFO full flag |
| rx_empty | input | 1 | Receive FIFO empty flag |
| rx_tmo | input | 1 | Receive FIFO timeout flag |
| dma0_ack | input | 1 | Acknowledge of external channel 0 |
| dma1_ack | input | 1 | Acknowledge of external channel 1 |
| dma0_req | output | 1 | Request of external channel 0 |
| dma1_req | output | 1 | Request of external channel 1 |

## Verification
The assertions assume that the FIFO flags agree with the levels: tx_full is only high at the full level, which lies above every transmit threshold, and rx_empty is only high at level 0, which lies below every receive threshold. The bench derives each flag directly from the level it drives, so the two never disagree. The assertions also assume that inputs change only between clock edges. The bench drives every input just after a falling edge.

// File: rtl/dmarq_pkg.sv
package dmarq_pkg;

  localparam int unsigned DIR_TX = 0;
  localparam int unsigned DIR_RX = 1;

  // level strictly below a threshold (transmit style)
  function automatic logic lvl_below(input logic [15:0] lvl, input logic [15:0] th);
    return lvl < th;
  endfunction

  // level at or above a threshold (receive style)
  function automatic logic lvl_reached(input logic [15:0] lvl, input logic [15:0] th);
    return lvl >= th;
  endfunction

  // threshold picked by the select bit
  function automatic logic [15:0] pick_thr(input logic sel, input int unsigned lo,
                                           input int unsigned hi);
    return sel ? 16'(hi) : 16'(lo);
  endfunction

  // sticky request: set wins, otherwise hold until the clear flag
  function automatic logic hold_next(input logic held, input logic set, input logic clr);
    return set | (held & ~clr);
  endfunction

endpackage

// File: rtl/dmarq_level_cmp.sv
module dmarq_level_cmp
  import dmarq_pkg::*;
#(
  parameter int unsigned LVL_W  = 5,
  parameter int unsigned TH_LO  = 1,
  parameter int unsigned TH_HI  = 8,
  parameter bit          BELOW  = 1'b1
) (
  input  logic             thr_sel,
  input  logic [LVL_W-1:0] level,
  output logic             hit
);

  logic [15:0] thr;
  logic [15:0] lvl_ext;

  always_comb begin
    thr     = pick_thr(thr_sel, TH_LO, TH_HI);
    lvl_ext = 16'(level);
  end

  generate
    if (BELOW) begin : g_below
      assign hit = lvl_below(lvl_ext, thr);
    end else begin : g_reached
      assign hit = lvl_reached(lvl_ext, thr);
    end
  endgenerate

endmodule

// File: rtl/dmarq_burst_timer.sv
module dmarq_burst_timer #(
  parameter int unsigned BURST_CYC = 1050
) (
  input  logic clk,
  input  logic rst_n,
  input  logic port_en,
  input  logic fair_sel,
  input  logic active,
  output logic cut
);

  localparam int unsigned CW  = $clog2(BURST_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(BURST_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic          counting;

  assign counting = port_en & ~fair_sel & active;
  assign cut      = counting & (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!counting || cut) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R7: the count never passes the limit
  a_r7_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

  // R8: an idle cycle restarts the count
  a_r8_idle_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> cnt_q == '0);

endmodule

// File: rtl/dmarq_swap.sv
module dmarq_swap (
  input  logic swap_sel,
  input  logic tx_req,
  input  logic rx_req,
  output logic ch0_req,
  output logic ch1_req
);

  always_comb begin
    if (swap_sel) begin
      ch0_req = rx_req;
      ch1_req = tx_req;
    end else begin
      ch0_req = tx_req;
      ch1_req = rx_req;
    end
  end

endmodule

// File: rtl/dma_req_ctrl.sv
module dma_req_ctrl
  import dmarq_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 16,
  parameter int unsigned LVL_W      = $clog2(FIFO_DEPTH + 1),
  parameter int unsigned TX_TH_LO   = 1,
  parameter int unsigned TX_TH_HI   = 8,
  parameter int unsigned RX_TH_LO   = 4,
  parameter int unsigned RX_TH_HI   = 8,
  parameter int unsigned BURST_CYC  = 1050
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             port_en,
  input  logic             thr_sel,
  input  logic             fair_sel,
  input  logic             swap_sel,
  input  logic [LVL_W-1:0] tx_level,
  input  logic [LVL_W-1:0] rx_level,
  input  logic             tx_full,
  input  logic             rx_empty,
  input  logic             rx_tmo,
  input  logic             dma0_ack,
  input  logic             dma1_ack,
  output logic             dma0_req,
  output logic             dma1_req
);

  localparam int unsigned NDIR = 2;

  logic [LVL_W-1:0] lvl   [NDIR];
  logic [NDIR-1:0]  hit;       // threshold condition per direction
  logic [NDIR-1:0]  set;       // condition raising a request
  logic [NDIR-1:0]  done;      // FIFO full (tx) / empty (rx)
  logic [NDIR-1:0]  hold_q;
  logic [NDIR-1:0]  want;
  logic [NDIR-1:0]  req_q;
  logic             active;
  logic             cut;

  assign lvl[DIR_TX]  = tx_level;
  assign lvl[DIR_RX]  = rx_level;
  assign done[DIR_TX] = tx_full;
  assign done[DIR_RX] = rx_empty;
  assign set[DIR_TX]  = hit[DIR_TX];
  assign set[DIR_RX]  = hit[DIR_RX] | rx_tmo;

  generate
    for (genvar g = 0; g < NDIR; g++) begin : g_dir
      localparam int unsigned TL = (g == DIR_TX) ? TX_TH_LO : RX_TH_LO;
      localparam int unsigned TH = (g == DIR_TX) ? TX_TH_HI : RX_TH_HI;

      dmarq_level_cmp #(
        .LVL_W (LVL_W),
        .TH_LO (TL),
        .TH_HI (TH),
        .BELOW (g == DIR_TX)
      ) u_cmp (
        .thr_sel (thr_sel),
        .level   (lvl[g]),
        .hit     (hit[g])
      );

      always_comb begin
        if (fair_sel) want[g] = hold_next(hold_q[g], set[g], done[g]);
        else          want[g] = set[g];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          hold_q[g] <= 1'b0;
          req_q[g]  <= 1'b0;
        end else begin
          hold_q[g] <= port_en & hold_next(hold_q[g], set[g], done[g]);
          req_q[g]  <= port_en & want[g] & ~cut;
        end
      end

      // R2 / R3: condition at an enabled edge raises the request
      a_r3_set_raises: assert property (@(posedge clk) disable iff (!rst_n)
        port_en && set[g] && !cut |=> req_q[g]);

      // R6: hold policy drops the request on the full / empty flag
      a_r6_done_drops: assert property (@(posedge clk) disable iff (!rst_n)
        fair_sel && done[g] && !set[g] |=> !req_q[g]);

      // R5: demand policy drops the request once the condition is gone
      a_r5_demand_drops: assert property (@(posedge clk) disable iff (!rst_n)
        !fair_sel && !set[g] |=> !req_q[g]);
    end
  endgenerate

  assign active = (|req_q) | dma0_ack | dma1_ack;

  dmarq_burst_timer #(
    .BURST_CYC (BURST_CYC)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .port_en  (port_en),
    .fair_sel (fair_sel),
    .active   (active),
    .cut      (cut)
  );

  dmarq_swap u_swap (
    .swap_sel (swap_sel),
    .tx_req   (req_q[DIR_TX]),
    .rx_req   (req_q[DIR_RX]),
    .ch0_req  (dma0_req),
    .ch1_req  (dma1_req)
  );

  // R1: disabled port drives no request
  a_r1_off_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !port_en |=> !dma0_req && !dma1_req);

  // R7: a burst cut leaves both channels quiet for a cycle
  a_r7_cut_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    cut |=> !dma0_req && !dma1_req);

  // R8: hold policy is never cut
  a_r8_no_cut_in_hold: assert property (@(posedge clk) disable iff (!rst_n)
    fair_sel |-> !cut);

endmodule

// File: tb/sim_dma_req_ctrl.sv
module sim_dma_req_ctrl;

  localparam int unsigned LIM = 12;
  localparam int unsigned LW  = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic port_en = 1'b0, thr_sel = 1'b0, fair_sel = 1'b0, swap_sel = 1'b0;
  logic [LW-1:0] tx_level = '0, rx_level = '0;
  logic tx_full, rx_empty;
  logic rx_tmo = 1'b0, dma0_ack = 1'b0, dma1_ack = 1'b0;
  logic dma0_req, dma1_req;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  assign tx_full  = (tx_level == 5'd16);
  assign rx_empty = (rx_level == 5'd0);

  always #5 clk = ~clk;

  dma_req_ctrl #(.BURST_CYC(LIM)) u0 (
    .clk(clk), .rst_n(rst_n), .port_en(port_en), .thr_sel(thr_sel),
    .fair_sel(fair_sel), .swap_sel(swap_sel), .tx_level(tx_level),
    .rx_level(rx_level), .tx_full(tx_full), .rx_empty(rx_empty),
    .rx_tmo(rx_tmo), .dma0_ack(dma0_ack), .dma1_ack(dma1_ack),
    .dma0_req(dma0_req), .dma1_req(dma1_req)
  );

  // {en, thr, swap, tmo, tx_level, rx_level, exp0, exp1}
  localparam int NV = 12;
  localparam logic [15:0] VEC [NV] = '{
    {1'b1,1'b0,1'b0,1'b0,5'd0, 5'd0, 1'b1,1'b0},
    {1'b1,1'b0,1'b0,1'b0,5'd1, 5'd0, 1'b0,1'b0},
    {1'b1,1'b0,1'b0,1'b0,5'd1, 5'd4, 1'b0,1'b1},
    {1'b1,1'b0,1'b0,1'b0,5'd1, 5'd3, 1'b0,1'b0},
    {1'b1,1'b0,1'b0,1'b1,5'd1, 5'd3, 1'b0,1'b1},
    {1'b1,1'b1,1'b0,1'b0,5'd7, 5'd7, 1'b1,1'b0},
    {1'b1,1'b1,1'b0,1'b0,5'd8, 5'd8, 1'b0,1'b1},
    {1'b1,1'b1,1'b0,1'b0,5'd0, 5'd16,1'b1,1'b1},
    {1'b1,1'b0,1'b1,1'b0,5'd0, 5'd0, 1'b0,1'b1},
    {1'b1,1'b0,1'b1,1'b0,5'd5, 5'd5, 1'b1,1'b0},
    {1'b0,1'b0,1'b0,1'b0,5'd0, 5'd8, 1'b0,1'b0},
    {1'b1,1'b1,1'b1,1'b0,5'd3, 5'd2, 1'b0,1'b1}
  };

  task automatic check(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic go_idle();
    port_en = 1'b0; rx_tmo = 1'b0; dma0_ack = 1'b0; dma1_ack = 1'b0;
    tx_level = 5'd5; rx_level = 5'd0;
    tick(); tick(); tick();
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    // R1: reset holds requests low even with demand present
    port_en = 1'b1; tx_level = 5'd0; rx_level = 5'd10;
    tick(); tick();
    check("R1 reset dma0", dma0_req, 1'b0);
    check("R1 reset dma1", dma1_req, 1'b0);
    rst_n = 1'b1;
    port_en = 1'b0;
    tick();
    check("R1 disabled dma0", dma0_req, 1'b0);
    check("R1 disabled dma1", dma1_req, 1'b0);

    // R2 R3 R4 R9 vector table, demand policy
    fair_sel = 1'b0;
    for (int i = 0; i < NV; i++) begin
      go_idle();
      port_en  = VEC[i][15];
      thr_sel  = VEC[i][14];
      swap_sel = VEC[i][13];
      rx_tmo   = VEC[i][12];
      tx_level = VEC[i][11:7];
      rx_level = VEC[i][6:2];
      tick();
      check($sformatf("R2 R3 R4 R9 vec %0d dma0", i), dma0_req, VEC[i][1]);
      check($sformatf("R2 R3 R4 R9 vec %0d dma1", i), dma1_req, VEC[i][0]);
    end

    // R5: demand policy follows level
    go_idle();
    thr_sel = 1'b0; swap_sel = 1'b0; port_en = 1'b1; rx_level = 5'd6;
    tick();
    check("R5 rx up", dma1_req, 1'b1);
    rx_level = 5'd3;
    tick();
    check("R5 rx falls below threshold", dma1_req, 1'b0);

    // R7: burst cut after LIM active cycles
    go_idle();
    port_en = 1'b1; tx_level = 5'd0;
    for (int k = 0; k < LIM; k++) begin
      tick();
      check("R7 burst high", dma0_req, 1'b1);
    end
    tick();
    check("R7 cut cycle", dma0_req, 1'b0);
    tick();
    check("R7 resume", dma0_req, 1'b1);

    // R8: an idle cycle restarts the count
    go_idle();
    port_en = 1'b1; tx_level = 5'd0;
    for (int k = 0; k < 5; k++) tick();
    check("R8 pre-gap high", dma0_req, 1'b1);
    tx_level = 5'd5;
    tick();
    check("R8 gap low", dma0_req, 1'b0);
    tx_level = 5'd0;
    for (int k = 0; k < LIM; k++) begin
      tick();
      check("R8 fresh run high", dma0_req, 1'b1);
    end
    tick();
    check("R8 fresh run cut", dma0_req, 1'b0);

    // R8: acknowledge alone counts as activity
    go_idle();
    port_en = 1'b1; tx_level = 5'd5; dma1_ack = 1'b1;
    for (int k = 0; k < 5; k++) tick();
    tx_level = 5'd0;
    for (int k = 0; k < LIM - 6; k++) begin
      tick();
      check("R8 ack shortened burst high", dma0_req, 1'b1);
    end
    tick();
    check("R8 ack shortened burst cut", dma0_req, 1'b0);

    // R8: hold policy is never cut
    go_idle();
    fair_sel = 1'b1; port_en = 1'b1; tx_level = 5'd0;
    for (int k = 0; k < 3 * LIM; k++) begin
      tick();
      check("R8 hold no cut", dma0_req, 1'b1);
    end

    // R6: transmit held until full
    go_idle();
    fair_sel = 1'b1; thr_sel = 1'b0; port_en = 1'b1; tx_level = 5'd0;
    tick();
    check("R6 tx set", dma0_req, 1'b1);
    tx_level = 5'd5;
    tick(); tick();
    check("R6 tx held above threshold", dma0_req, 1'b1);
    tx_level = 5'd16;
    tick();
    check("R6 tx dropped on full", dma0_req, 1'b0);
    tx_level = 5'd5;
    tick();
    check("R6 tx stays low", dma0_req, 1'b0);

    // R6: receive held until empty, also after a timeout
    go_idle();
    fair_sel = 1'b1; port_en = 1'b1; tx_level = 5'd5; rx_level = 5'd2;
    rx_tmo = 1'b1;
    tick();
    check("R6 rx set by timeout", dma1_req, 1'b1);
    rx_tmo = 1'b0;
    tick(); tick();
    check("R6 rx held", dma1_req, 1'b1);
    rx_level = 5'd0;
    tick();
    check("R6 rx dropped on empty", dma1_req, 1'b0);
    rx_level = 5'd2;
    tick();
    check("R6 rx stays low", dma1_req, 1'b0);

    // R1: disable clears a held request
    rx_level = 5'd5;
    tick();
    check("R1 rx held before disable", dma1_req, 1'b1);
    port_en = 1'b0;
    tick();
    check("R1 disable clears", dma1_req, 1'b0);

    finish_run();
  end

endmodule